// File: doc/BRIEF.md
# Single-Thread Fetch/Execute Sequencer

This block is the control sequencer of a small in-order core that holds one instruction in flight at a time. It issues an instruction fetch, waits for the fetch response, and then either completes the instruction in the same step or hands it to the data side. On the data side it waits for address translation, issues the data request and waits for the data response. Only after the instruction completes does it start the next fetch. Both memory ports use the same handshake. A request is offered and either accepted or refused in the same cycle. After a refusal the request is offered again only while the port signals retry. A response can come back not-acknowledged, and the request is then reissued.

The sequencer also controls the thread's lifecycle. Activation starts the first fetch after a programmable number of cycles. Suspension parks the thread. Switch-out and take-over hand the core between execution contexts. A drain handshake brings the core to a quiescent point. Drained is reported at once when nothing is in flight. Otherwise it is reported when the outstanding access completes, and no new fetch starts until drain is released. Interrupts are sampled at each fetch, and fetch, execute and translation faults redirect to a fixed handler address. Two counters report elapsed cycles and instructions that retired without a fault.

Top module: `fx_seq`

## Requirements
- R1: After reset, state_o is 0 (idle), pc_o is RESET_PC (0x1000), both counters are 0, drained_o is low, and no fetch or data request is driven.
- R2: When activate_i is sampled in idle with delay value D, the state becomes 1 (running). The first if_req_o appears in the cycle after the (D+1)-th following clock edge.
- R3: A fetch refused with if_accept_i low moves the state to 2 (fetch retry). In that state the request is offered again only while if_retry_i is high. Acceptance moves the state to 3 (fetch wait).
- R4: A fetch response flagged not-acknowledged reissues the same request in that cycle. If the reissue is refused, the state becomes 2.
- R5: A non-memory instruction, or a data prefetch, completes on its fetch response. pc_o advances by 4, retired_o increments, and the next fetch from the new pc_o is offered in the next cycle.
- R6: A memory instruction moves the state to 4 (translation wait). On translation done the data request is offered. Refusal gives state 5 (data retry, re-offered only on dm_retry_i) and acceptance gives state 6 (data wait). A not-acknowledged data response reissues the request. A normal data response returns the state to 1, advances pc_o by 4 and increments retired_o.
- R7: A fetch fault present when a fetch would be offered suppresses the request and loads FAULT_VEC (0x100). An execute fault or a translation fault also loads FAULT_VEC. retired_o does not change on any fault.
- R8: When a fetch would be offered and irq_i is high, the interrupt is taken unless the previous instruction was delayed-commit. Taking it suppresses the request, pulses irq_ack_o and loads IRQ_VEC (0x200). The fetch that follows does not sample irq_i.
- R9: suspend_i in state 1 moves the state to 0 and no further fetch is offered. suspend_i in state 0 has no effect.
- R10: drain_req_i in state 0, 1 or 7 raises drained_o on the next edge. No fetch is offered while drained_o is high. resume_i clears drained_o, and in state 1 fetching restarts in the following cycle.
- R11: drain_req_i while an access is in flight leaves drained_o low until that access completes. The completion advances pc_o by 4, returns the state to 1, raises drained_o and offers no new fetch. A drain request in the same cycle as the completing response counts as already in effect.
- R12: switch_out_i in state 0 or 1 moves the state to 7 (switched out). take_over_i leaves state 7 for 1 if thread_active_i is high, and for 0 if it is low. cycles_o increments on every edge except those taken while in state 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| activate_i | input | 1 | Start the thread from idle |
| act_delay_i | input | DLY_W | Cycles before the first fetch after activation |
| suspend_i | input | 1 | Park the thread |
| switch_out_i | input | 1 | Hand the core away |
| take_over_i | input | 1 | Take the core back |
| thread_active_i | input | 1 | Thread state on take-over |
| drain_req_i | input | 1 | Request quiescence |
| resume_i | input | 1 | Release drain |
| drained_o | output | 1 | Core is quiescent |
| irq_i | input | 1 | Pending interrupt |
| irq_ack_o | output | 1 | Interrupt taken this cycle |
| if_req_o | output | 1 | Fetch request offered |
| if_addr_o | output | AW | Fetch address |
| if_accept_i | input | 1 | Fetch port accepts the offered request |
| if_retry_i | input | 1 | Fetch port ready for a re-offer |
| if_fault_i | input | 1 | Fetch translation fault |
| if_rsp_valid_i | input | 1 | Fetch response |
| if_rsp_nack_i | input | 1 | Fetch response not acknowledged |
| dec_mem_i | input | 1 | Fetched instruction accesses memory |
| dec_prefetch_i | input | 1 | Fetched instruction is a data prefetch |
| dec_delayed_i | input | 1 | Fetched instruction is delayed-commit |
| dec_fault_i | input | 1 | Execute fault of a non-memory instruction |
| dx_done_i | input | 1 | Data translation finished |
| dx_fault_i | input | 1 | Data translation fault |
| dm_req_o | output | 1 | Data request offered |
| dm_accept_i | input | 1 | Data port accepts the offered request |
| dm_retry_i | input | 1 | Data port ready for a re-offer |
| dm_rsp_valid_i | input | 1 | Data response |
| dm_rsp_nack_i | input | 1 | Data response not acknowledged |
| state_o | output | 3 | Sequencer state code |
| pc_o | output | AW | Program counter |
| retired_o | output | CW | Fault-free completions |
| cycles_o | output | CW | Elapsed cycles outside switch-out |

## Verification
A drain request can fall in the same cycle as the response that completes the access in flight. The bench drives drain_req_i and if_rsp_valid_i together while the state is fetch wait. It expects drained_o to be high after that edge, pc_o to have advanced by 4 with retired_o unchanged, and no fetch to be offered in the cycles that follow. An interrupt can also coincide with a fetch fault at the same fetch opportunity. The random stream produces this case, and the bench model expects the interrupt to win unless the previous instruction was delayed-commit.

// File: rtl/fx_seq_pkg.sv
package fx_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RUN      = 3'd1,
    ST_IF_RETRY = 3'd2,
    ST_IF_WAIT  = 3'd3,
    ST_DX_WAIT  = 3'd4,
    ST_DM_RETRY = 3'd5,
    ST_DM_WAIT  = 3'd6,
    ST_SWOUT    = 3'd7
  } seq_state_e;

  localparam int unsigned PERF_NUM = 2;
  localparam int unsigned PERF_CYC = 0;
  localparam int unsigned PERF_RET = 1;
endpackage

// File: rtl/fx_act_timer.sv
module fx_act_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         cancel_i,
  input  logic [W-1:0] val_i,
  output logic         fire_o
);
  logic [W-1:0] cnt_q;
  logic         armed_q;

  assign fire_o = armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= val_i;
      armed_q <= 1'b1;
    end else if (cancel_i || fire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fx_perf_cnt.sv
module fx_perf_cnt #(
  parameter int unsigned N = 2,
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        inc_i,
  output logic [N-1:0][W-1:0] cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (inc_i[g]) q <= q + 1'b1;
    end
    assign cnt_o[g] = q;
  end
endmodule

// File: rtl/fx_seq.sv
module fx_seq
  import fx_seq_pkg::*;
#(
  parameter int unsigned    AW         = 32,
  parameter int unsigned    DLY_W      = 8,
  parameter int unsigned    CW         = 32,
  parameter int unsigned    INST_BYTES = 4,
  parameter logic [AW-1:0]  RESET_PC   = 32'h0000_1000,
  parameter logic [AW-1:0]  FAULT_VEC  = 32'h0000_0100,
  parameter logic [AW-1:0]  IRQ_VEC    = 32'h0000_0200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             activate_i,
  input  logic [DLY_W-1:0] act_delay_i,
  input  logic             suspend_i,
  input  logic             switch_out_i,
  input  logic             take_over_i,
  input  logic             thread_active_i,
  input  logic             drain_req_i,
  input  logic             resume_i,
  output logic             drained_o,
  input  logic             irq_i,
  output logic             irq_ack_o,
  output logic             if_req_o,
  output logic [AW-1:0]    if_addr_o,
  input  logic             if_accept_i,
  input  logic             if_retry_i,
  input  logic             if_fault_i,
  input  logic             if_rsp_valid_i,
  input  logic             if_rsp_nack_i,
  input  logic             dec_mem_i,
  input  logic             dec_prefetch_i,
  input  logic             dec_delayed_i,
  input  logic             dec_fault_i,
  input  logic             dx_done_i,
  input  logic             dx_fault_i,
  output logic             dm_req_o,
  input  logic             dm_accept_i,
  input  logic             dm_retry_i,
  input  logic             dm_rsp_valid_i,
  input  logic             dm_rsp_nack_i,
  output logic [2:0]       state_o,
  output logic [AW-1:0]    pc_o,
  output logic [CW-1:0]    retired_o,
  output logic [CW-1:0]    cycles_o
);
  localparam logic [AW-1:0] PC_STEP = AW'(INST_BYTES);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          fetch_pend_q, fetch_pend_d;
  logic          draining_q, draining_d;
  logic          drained_q, drained_d;
  logic          prev_dly_q, prev_dly_d;
  logic          cur_dly_q, cur_dly_d;
  logic          ret_inc, tmr_load, tmr_cancel, tmr_fire;
  logic          hold, drain_eff, quiet_state;
  logic [PERF_NUM-1:0]         perf_inc;
  logic [PERF_NUM-1:0][CW-1:0] perf_cnt;

  fx_act_timer #(.W(DLY_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .cancel_i (tmr_cancel),
    .val_i    (act_delay_i),
    .fire_o   (tmr_fire)
  );

  assign quiet_state = (state_q == ST_IDLE) || (state_q == ST_RUN) || (state_q == ST_SWOUT);
  assign hold        = drained_q | draining_q | drain_req_i;
  assign drain_eff   = draining_q | drain_req_i;

  always_comb begin
    state_d      = state_q;
    pc_d         = pc_q;
    fetch_pend_d = fetch_pend_q;
    draining_d   = draining_q;
    drained_d    = drained_q;
    prev_dly_d   = prev_dly_q;
    cur_dly_d    = cur_dly_q;
    if_req_o     = 1'b0;
    dm_req_o     = 1'b0;
    irq_ack_o    = 1'b0;
    ret_inc      = 1'b0;
    tmr_load     = 1'b0;
    tmr_cancel   = 1'b0;

    if (drain_req_i) begin
      if (quiet_state) drained_d  = 1'b1;
      else             draining_d = 1'b1;
    end
    if (resume_i) begin
      drained_d  = 1'b0;
      draining_d = 1'b0;
      if (state_q == ST_RUN) begin
        fetch_pend_d = 1'b1;
        tmr_cancel   = 1'b1;
      end
    end

    unique case (state_q)
      ST_IDLE: begin
        if (switch_out_i) begin
          state_d = ST_SWOUT;
        end else if (activate_i) begin
          state_d      = ST_RUN;
          fetch_pend_d = 1'b0;
          tmr_load     = 1'b1;
        end
      end
      ST_RUN: begin
        if (switch_out_i) begin
          state_d      = ST_SWOUT;
          fetch_pend_d = 1'b0;
          tmr_cancel   = 1'b1;
        end else if (suspend_i) begin
          state_d      = ST_IDLE;
          fetch_pend_d = 1'b0;
          tmr_cancel   = 1'b1;
        end else begin
          if (tmr_fire) fetch_pend_d = 1'b1;
          if (fetch_pend_q && !hold) begin
            if (irq_i && !prev_dly_q) begin
              irq_ack_o  = 1'b1;
              pc_d       = IRQ_VEC;
              prev_dly_d = 1'b1;  // mask sampling on the handler's first fetch
            end else if (if_fault_i) begin
              pc_d       = FAULT_VEC;
              prev_dly_d = 1'b0;
            end else begin
              if_req_o     = 1'b1;
              fetch_pend_d = 1'b0;
              state_d      = if_accept_i ? ST_IF_WAIT : ST_IF_RETRY;
            end
          end
        end
      end
      ST_IF_RETRY: begin
        if (if_retry_i) begin
          if_req_o = 1'b1;
          if (if_accept_i) state_d = ST_IF_WAIT;
        end
      end
      ST_IF_WAIT: begin
        if (if_rsp_valid_i) begin
          if (if_rsp_nack_i) begin
            if_req_o = 1'b1;
            if (!if_accept_i) state_d = ST_IF_RETRY;
          end else if (drain_eff) begin
            pc_d         = pc_q + PC_STEP;
            state_d      = ST_RUN;
            fetch_pend_d = 1'b0;
            drained_d    = 1'b1;
            draining_d   = 1'b0;
          end else if (dec_mem_i && !dec_prefetch_i) begin
            cur_dly_d = dec_delayed_i;
            state_d   = ST_DX_WAIT;
          end else begin
            state_d      = ST_RUN;
            fetch_pend_d = 1'b1;
            pc_d         = dec_fault_i ? FAULT_VEC : pc_q + PC_STEP;
            ret_inc      = !dec_fault_i;
            prev_dly_d   = dec_delayed_i && !dec_fault_i;
          end
        end
      end
      ST_DX_WAIT: begin
        if (dx_done_i) begin
          if (dx_fault_i) begin
            pc_d       = FAULT_VEC;
            prev_dly_d = 1'b0;
            state_d    = ST_RUN;
            if (drain_eff) begin
              fetch_pend_d = 1'b0;
              drained_d    = 1'b1;
              draining_d   = 1'b0;
            end else begin
              fetch_pend_d = 1'b1;
            end
          end else begin
            dm_req_o = 1'b1;
            state_d  = dm_accept_i ? ST_DM_WAIT : ST_DM_RETRY;
          end
        end
      end
      ST_DM_RETRY: begin
        if (dm_retry_i) begin
          dm_req_o = 1'b1;
          if (dm_accept_i) state_d = ST_DM_WAIT;
        end
      end
      ST_DM_WAIT: begin
        if (dm_rsp_valid_i) begin
          if (dm_rsp_nack_i) begin
            dm_req_o = 1'b1;
            if (!dm_accept_i) state_d = ST_DM_RETRY;
          end else begin
            pc_d       = pc_q + PC_STEP;
            ret_inc    = 1'b1;
            prev_dly_d = cur_dly_q;
            state_d    = ST_RUN;
            if (drain_eff) begin
              fetch_pend_d = 1'b0;
              drained_d    = 1'b1;
              draining_d   = 1'b0;
            end else begin
              fetch_pend_d = 1'b1;
            end
          end
        end
      end
      ST_SWOUT: begin
        if (take_over_i) begin
          state_d      = thread_active_i ? ST_RUN : ST_IDLE;
          fetch_pend_d = thread_active_i;
          tmr_cancel   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pc_q         <= RESET_PC;
      fetch_pend_q <= 1'b0;
      draining_q   <= 1'b0;
      drained_q    <= 1'b0;
      prev_dly_q   <= 1'b0;
      cur_dly_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      pc_q         <= pc_d;
      fetch_pend_q <= fetch_pend_d;
      draining_q   <= draining_d;
      drained_q    <= drained_d;
      prev_dly_q   <= prev_dly_d;
      cur_dly_q    <= cur_dly_d;
    end
  end

  assign perf_inc[PERF_CYC] = (state_q != ST_SWOUT);
  assign perf_inc[PERF_RET] = ret_inc;

  fx_perf_cnt #(.N(PERF_NUM), .W(CW)) u_perf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (perf_inc),
    .cnt_o  (perf_cnt)
  );

  assign cycles_o  = perf_cnt[PERF_CYC];
  assign retired_o = perf_cnt[PERF_RET];
  assign state_o   = state_q;
  assign pc_o      = pc_q;
  assign if_addr_o = pc_q;
  assign drained_o = drained_q;
endmodule

// File: rtl/fx_seq_chk.sv
module fx_seq_chk
  import fx_seq_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    state_o,
  input logic          if_req_o,
  input logic          dm_req_o,
  input logic          if_retry_i,
  input logic          if_accept_i,
  input logic          suspend_i,
  input logic          switch_out_i,
  input logic          drain_req_i,
  input logic          resume_i,
  input logic          drained_o,
  input logic          irq_ack_o,
  input logic [CW-1:0] retired_o,
  input logic [CW-1:0] cycles_o
);
  a_r3_retry_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IF_RETRY && if_retry_i && if_accept_i) |=> (state_o == ST_IF_WAIT));

  a_r3_fetch_req_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_req_o |-> (state_o == ST_RUN || state_o == ST_IF_RETRY || state_o == ST_IF_WAIT));

  a_r6_data_req_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_req_o |-> (state_o == ST_DX_WAIT || state_o == ST_DM_RETRY || state_o == ST_DM_WAIT));

  a_r9_suspend_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && suspend_i && !switch_out_i) |=> (state_o == ST_IDLE));

  a_r10_drain_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && drain_req_i && !resume_i) |=> drained_o);

  a_r10_no_fetch_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_o |-> !if_req_o);

  a_r8_irq_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> !if_req_o);

  a_r5_retire_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (retired_o == $past(retired_o) || retired_o == $past(retired_o) + 1'b1));

  a_r12_cycles_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SWOUT) |=> $stable(cycles_o));
endmodule

bind fx_seq fx_seq_chk #(.CW(CW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_o      (state_o),
  .if_req_o     (if_req_o),
  .dm_req_o     (dm_req_o),
  .if_retry_i   (if_retry_i),
  .if_accept_i  (if_accept_i),
  .suspend_i    (suspend_i),
  .switch_out_i (switch_out_i),
  .drain_req_i  (drain_req_i),
  .resume_i     (resume_i),
  .drained_o    (drained_o),
  .irq_ack_o    (irq_ack_o),
  .retired_o    (retired_o),
  .cycles_o     (cycles_o)
);

// File: tb/fx_seq_tb_top.sv
module fx_seq_tb_top;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] F_VEC  = 32'h0000_0100;
  localparam logic [31:0] I_VEC  = 32'h0000_0200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic activate_i = 0, suspend_i = 0, switch_out_i = 0, take_over_i = 0, thread_active_i = 0;
  logic drain_req_i = 0, resume_i = 0, irq_i = 0;
  logic [7:0] act_delay_i = '0;
  logic if_accept_i = 0, if_retry_i = 0, if_fault_i = 0, if_rsp_valid_i = 0, if_rsp_nack_i = 0;
  logic dec_mem_i = 0, dec_prefetch_i = 0, dec_delayed_i = 0, dec_fault_i = 0;
  logic dx_done_i = 0, dx_fault_i = 0;
  logic dm_accept_i = 0, dm_retry_i = 0, dm_rsp_valid_i = 0, dm_rsp_nack_i = 0;
  logic drained_o, irq_ack_o, if_req_o, dm_req_o;
  logic [31:0] if_addr_o, pc_o, retired_o, cycles_o;
  logic [2:0]  state_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_pc;
  logic [31:0] m_ret;
  bit m_dly;

  always #4 clk = ~clk;

  fx_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .activate_i(activate_i), .act_delay_i(act_delay_i),
    .suspend_i(suspend_i), .switch_out_i(switch_out_i), .take_over_i(take_over_i),
    .thread_active_i(thread_active_i), .drain_req_i(drain_req_i), .resume_i(resume_i),
    .drained_o(drained_o), .irq_i(irq_i), .irq_ack_o(irq_ack_o), .if_req_o(if_req_o),
    .if_addr_o(if_addr_o), .if_accept_i(if_accept_i), .if_retry_i(if_retry_i),
    .if_fault_i(if_fault_i), .if_rsp_valid_i(if_rsp_valid_i), .if_rsp_nack_i(if_rsp_nack_i),
    .dec_mem_i(dec_mem_i), .dec_prefetch_i(dec_prefetch_i), .dec_delayed_i(dec_delayed_i),
    .dec_fault_i(dec_fault_i), .dx_done_i(dx_done_i), .dx_fault_i(dx_fault_i),
    .dm_req_o(dm_req_o), .dm_accept_i(dm_accept_i), .dm_retry_i(dm_retry_i),
    .dm_rsp_valid_i(dm_rsp_valid_i), .dm_rsp_nack_i(dm_rsp_nack_i), .state_o(state_o),
    .pc_o(pc_o), .retired_o(retired_o), .cycles_o(cycles_o)
  );

  function automatic logic [31:0] next_pc(input logic [31:0] pc, input bit flt);
    return flt ? F_VEC : pc + 32'd4;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // one instruction from a pending fetch in state 1
  task automatic do_instr();
    bit r_irq  = ($urandom % 8) == 0;
    bit r_ff   = ($urandom % 12) == 0;
    bit r_ref  = ($urandom % 4) == 0;
    bit r_nack = ($urandom % 5) == 0;
    bit r_mem  = ($urandom % 3) == 0;
    bit r_pref = r_mem && (($urandom % 4) == 0);
    bit r_dly  = ($urandom % 4) == 0;
    bit r_ef   = ($urandom % 10) == 0;
    bit r_xf   = ($urandom % 10) == 0;
    bit r_dref = ($urandom % 4) == 0;
    bit r_dnak = ($urandom % 5) == 0;
    bit is_mem = r_mem && !r_pref;
    bit eflt   = r_ef && !is_mem;
    irq_i = r_irq;
    if_fault_i = r_ff;
    #1;
    if (r_irq && !m_dly) begin
      chk(irq_ack_o && !if_req_o, "R8 irq taken", {irq_ack_o, if_req_o}, 2'b10);
      tick();
      irq_i = 0; if_fault_i = 0;
      m_pc = I_VEC; m_dly = 1;
      chk(pc_o == m_pc, "R8 irq vector", pc_o, m_pc);
      return;
    end
    if (r_irq) chk(!irq_ack_o, "R8 irq masked after delayed-commit", irq_ack_o, 0);
    if (r_ff) begin
      chk(!if_req_o, "R7 fetch fault suppresses request", if_req_o, 0);
      tick();
      irq_i = 0; if_fault_i = 0;
      m_pc = F_VEC; m_dly = 0;
      chk(pc_o == m_pc, "R7 fetch fault vector", pc_o, m_pc);
      return;
    end
    chk(if_req_o && if_addr_o == m_pc, "R5 fetch offered at pc", if_addr_o, m_pc);
    if_accept_i = !r_ref;
    tick();
    irq_i = 0; if_accept_i = 0;
    if (r_ref) begin
      chk(state_o == 3'd2, "R3 refused fetch", state_o, 2);
      chk(!if_req_o, "R3 no re-offer without retry", if_req_o, 0);
      tick();
      if_retry_i = 1; if_accept_i = 1;
      #1;
      chk(if_req_o && if_addr_o == m_pc, "R3 re-offer on retry", if_addr_o, m_pc);
      tick();
      if_retry_i = 0; if_accept_i = 0;
    end
    chk(state_o == 3'd3, "R3 fetch wait", state_o, 3);
    if (r_nack) begin
      if_rsp_valid_i = 1; if_rsp_nack_i = 1;
      #1;
      chk(if_req_o, "R4 nack reissue", if_req_o, 1);
      tick();
      if_rsp_valid_i = 0; if_rsp_nack_i = 0;
      chk(state_o == 3'd2, "R4 refused reissue", state_o, 2);
      if_retry_i = 1; if_accept_i = 1;
      tick();
      if_retry_i = 0; if_accept_i = 0;
    end
    if_rsp_valid_i = 1; dec_mem_i = r_mem; dec_prefetch_i = r_pref;
    dec_delayed_i = r_dly; dec_fault_i = eflt;
    tick();
    if_rsp_valid_i = 0; dec_mem_i = 0; dec_prefetch_i = 0; dec_delayed_i = 0; dec_fault_i = 0;
    if (is_mem) begin
      chk(state_o == 3'd4, "R6 translation wait", state_o, 4);
      dx_done_i = 1; dx_fault_i = r_xf; dm_accept_i = !r_dref;
      #1;
      if (!r_xf) chk(dm_req_o, "R6 data request", dm_req_o, 1);
      tick();
      dx_done_i = 0; dx_fault_i = 0; dm_accept_i = 0;
      if (r_xf) begin
        m_pc = F_VEC; m_dly = 0;
        chk(state_o == 3'd1 && pc_o == m_pc, "R7 translation fault", pc_o, m_pc);
        chk(retired_o == m_ret, "R7 no retire on fault", retired_o, m_ret);
        return;
      end
      if (r_dref) begin
        chk(state_o == 3'd5, "R6 data retry", state_o, 5);
        chk(!dm_req_o, "R6 no data re-offer without retry", dm_req_o, 0);
        dm_retry_i = 1; dm_accept_i = 1;
        tick();
        dm_retry_i = 0; dm_accept_i = 0;
      end
      chk(state_o == 3'd6, "R6 data wait", state_o, 6);
      if (r_dnak) begin
        dm_rsp_valid_i = 1; dm_rsp_nack_i = 1; dm_accept_i = 1;
        #1;
        chk(dm_req_o, "R6 data nack reissue", dm_req_o, 1);
        tick();
        dm_rsp_valid_i = 0; dm_rsp_nack_i = 0; dm_accept_i = 0;
        chk(state_o == 3'd6, "R6 wait after reissue", state_o, 6);
      end
      dm_rsp_valid_i = 1;
      tick();
      dm_rsp_valid_i = 0;
      m_pc = m_pc + 32'd4; m_ret = m_ret + 1; m_dly = r_dly;
    end else begin
      m_pc = next_pc(m_pc, eflt);
      if (!eflt) m_ret = m_ret + 1;
      m_dly = r_dly && !eflt;
    end
    chk(state_o == 3'd1 && pc_o == m_pc, "R5 completion pc", pc_o, m_pc);
    chk(retired_o == m_ret, "R7 retired count", retired_o, m_ret);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] c0;
    logic [31:0] c1;
    int j;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    chk(state_o == 3'd0, "R1 reset state", state_o, 0);
    chk(pc_o == RST_PC, "R1 reset pc", pc_o, RST_PC);
    chk(retired_o == 0 && cycles_o == 0, "R1 counters", retired_o + cycles_o, 0);
    chk(!drained_o && !if_req_o && !dm_req_o, "R1 outputs idle", {drained_o, if_req_o, dm_req_o}, 0);
    // R9 suspend in idle
    suspend_i = 1; tick(); suspend_i = 0;
    chk(state_o == 3'd0 && pc_o == RST_PC, "R9 suspend in idle ignored", state_o, 0);
    // R10 drain in idle
    drain_req_i = 1; tick(); drain_req_i = 0;
    chk(drained_o, "R10 drain idle", drained_o, 1);
    resume_i = 1; tick(); resume_i = 0;
    chk(!drained_o, "R10 resume clears", drained_o, 0);
    // R2 activation delay
    act_delay_i = 8'd3; activate_i = 1; tick(); activate_i = 0;
    chk(state_o == 3'd1, "R2 running", state_o, 1);
    j = 0;
    while (!if_req_o && j < 40) begin tick(); j++; end
    chk(j == 4, "R2 first fetch delay", j, 4);
    if_accept_i = 0; tick();
    chk(state_o == 3'd2, "R3 refused first fetch", state_o, 2);
    if_retry_i = 1; if_accept_i = 1; tick(); if_retry_i = 0; if_accept_i = 0;
    chk(state_o == 3'd3, "R3 accepted retry", state_o, 3);
    if_rsp_valid_i = 1; tick(); if_rsp_valid_i = 0;
    m_pc = RST_PC + 32'd4; m_ret = 1; m_dly = 0;
    chk(pc_o == m_pc && retired_o == m_ret, "R5 first completion", pc_o, m_pc);
    #1;
    chk(if_req_o && if_addr_o == m_pc, "R5 next fetch offered", if_addr_o, m_pc);
    // R9 suspend while running
    suspend_i = 1; tick(); suspend_i = 0;
    chk(state_o == 3'd0, "R9 suspend to idle", state_o, 0);
    for (int k = 0; k < 3; k++) begin
      chk(!if_req_o, "R9 no fetch after suspend", if_req_o, 0);
      tick();
    end
    // R10 drain while running
    act_delay_i = 8'd0; activate_i = 1; tick(); activate_i = 0;
    drain_req_i = 1; tick(); drain_req_i = 0;
    chk(drained_o, "R10 drain running", drained_o, 1);
    for (int k = 0; k < 3; k++) begin
      chk(!if_req_o, "R10 no fetch while drained", if_req_o, 0);
      tick();
    end
    resume_i = 1; tick(); resume_i = 0;
    chk(if_req_o && if_addr_o == m_pc, "R10 fetch after resume", if_addr_o, m_pc);
    // R11 drain with fetch in flight
    if_accept_i = 1; tick(); if_accept_i = 0;
    drain_req_i = 1; tick(); drain_req_i = 0;
    chk(!drained_o, "R11 drained held while in flight", drained_o, 0);
    if_rsp_valid_i = 1; tick(); if_rsp_valid_i = 0;
    m_pc = m_pc + 32'd4;
    chk(drained_o && state_o == 3'd1, "R11 drained after fetch completes", drained_o, 1);
    chk(pc_o == m_pc && retired_o == m_ret, "R11 pc advanced no retire", pc_o, m_pc);
    chk(!if_req_o, "R11 no new fetch", if_req_o, 0);
    resume_i = 1; tick(); resume_i = 0;
    // R11 same-cycle drain and response
    if_accept_i = 1; tick(); if_accept_i = 0;
    drain_req_i = 1; if_rsp_valid_i = 1; tick(); drain_req_i = 0; if_rsp_valid_i = 0;
    m_pc = m_pc + 32'd4;
    chk(drained_o && pc_o == m_pc, "R11 same-cycle drain", pc_o, m_pc);
    chk(retired_o == m_ret && !if_req_o, "R11 same-cycle no fetch", retired_o, m_ret);
    resume_i = 1; tick(); resume_i = 0;
    // R11 drain with data access in flight
    if_accept_i = 1; tick(); if_accept_i = 0;
    if_rsp_valid_i = 1; dec_mem_i = 1; tick(); if_rsp_valid_i = 0; dec_mem_i = 0;
    dx_done_i = 1; dm_accept_i = 1; tick(); dx_done_i = 0; dm_accept_i = 0;
    chk(state_o == 3'd6, "R6 directed data wait", state_o, 6);
    drain_req_i = 1; tick(); drain_req_i = 0;
    chk(!drained_o, "R11 data in flight", drained_o, 0);
    dm_rsp_valid_i = 1; tick(); dm_rsp_valid_i = 0;
    m_pc = m_pc + 32'd4; m_ret = m_ret + 1;
    chk(drained_o && pc_o == m_pc && retired_o == m_ret, "R11 data completes then drained", pc_o, m_pc);
    chk(!if_req_o, "R11 no fetch after data drain", if_req_o, 0);
    resume_i = 1; tick(); resume_i = 0;
    // R12 switch out and take over
    switch_out_i = 1; tick(); switch_out_i = 0;
    chk(state_o == 3'd7, "R12 switched out", state_o, 7);
    c0 = cycles_o;
    repeat (5) tick();
    chk(cycles_o == c0, "R12 cycles frozen", cycles_o, c0);
    drain_req_i = 1; tick(); drain_req_i = 0;
    chk(drained_o, "R10 drain switched out", drained_o, 1);
    resume_i = 1; tick(); resume_i = 0;
    take_over_i = 1; thread_active_i = 0; tick(); take_over_i = 0;
    chk(state_o == 3'd0 && cycles_o == c0, "R12 take over inactive", state_o, 0);
    c1 = cycles_o;
    tick();
    chk(cycles_o == c1 + 1, "R12 cycles resume counting", cycles_o, c1 + 1);
    switch_out_i = 1; tick(); switch_out_i = 0;
    take_over_i = 1; thread_active_i = 1; tick(); take_over_i = 0; thread_active_i = 0;
    chk(state_o == 3'd1, "R12 take over active", state_o, 1);
    // random stream
    for (int n = 0; n < 300; n++) do_instr();
    finish_run();
  end
endmodule